// File: doc/BRIEF.md
# Depth-Cascade FIFO Token Controller

This block builds one deep first-in/first-out buffer out of a ring of identical buffer slices. Each slice holds a fixed number of words. A write token and a read token travel around the ring. Only the slice holding the write token stores incoming words. Only the slice holding the read token supplies outgoing words. When a slice stores into, or pops from, its last physical location, it passes the matching token on to the next slice. The last slice passes its tokens back to the first. The words therefore occupy one continuous circular buffer of `NUM_SLICES * SLICE_DEPTH` entries.

The top level offers a single write port, a single read port with first-word fall-through data, and composite empty and full flags. The composite flags are formed as an AND across all slices. A slice strapped as first-load holds both tokens after reset. Each slice passes tokens over a two-strobe link: one single-cycle strobe for the write token and one for the read token.

In cascade mode, each slice ignores its retransmit input and holds its half-full output low. A slice built as standalone (its token input grounded) keeps both of those features and does not use tokens.

Top module: `cascade_fifo_top`

## Requirements
- R1: While and after reset, slice 0 holds both tokens (`wr_token_o` and `rd_token_o` both equal 1), the other slices hold none, `empty_o` is 1 and `full_o` is 0.
- R2: In every cycle out of reset, exactly one bit of `wr_token_o` is set. Bit i means slice i, and an accepted write is stored by that slice.
- R3: In every cycle out of reset, exactly one bit of `rd_token_o` is set, and the read data comes from that slice.
- R4: A write accepted into location `SLICE_DEPTH-1` of the write-token holder moves the write token to the next slice from the following cycle. After g accepted writes, the write token sits in slice (g / SLICE_DEPTH) mod NUM_SLICES.
- R5: A read accepted from location `SLICE_DEPTH-1` of the read-token holder moves the read token to the next slice from the following cycle. After g accepted reads, the read token sits in slice (g / SLICE_DEPTH) mod NUM_SLICES.
- R6: A token leaving slice NUM_SLICES-1 wraps around to slice 0.
- R7: Whenever `empty_o` is 0, `rd_data_o` shows the oldest unread word. Words come out in write order across slice boundaries.
- R8: `empty_o` is 1 exactly when no words are held. `full_o` is 1 exactly when `NUM_SLICES*SLICE_DEPTH` words are held.
- R9: A write while `full_o` is 1 is ignored. A read while `empty_o` is 0 is required for a pop, so a read while empty is ignored. Neither changes the tokens, the flags or the stored words.
- R10: `retransmit_i` has no effect on the read order, and `half_full_o` stays 0 in cascade mode.
- R11: When the buffer is neither empty nor full, a write and a read in the same cycle are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read request (pops the head word) |
| retransmit_i | input | 1 | Retransmit request, inhibited in cascade mode |
| rd_data_o | output | DATA_W | Head word (first-word fall-through) |
| empty_o | output | 1 | Composite empty flag |
| full_o | output | 1 | Composite full flag |
| half_full_o | output | 1 | Half-full flag, held low in cascade mode |
| wr_token_o | output | NUM_SLICES | One-hot write-token owner |
| rd_token_o | output | NUM_SLICES | One-hot read-token owner |

## Verification
The assertions check the following on every cycle:
- The write token and the read token each stay one-hot.
- Every last-location strobe takes the token away from its sender.
- No slice writes while full or reads while empty.
- Retransmit never moves a cascaded read pointer.
- The composite flags hold, and the write token does not move, under requests that are blocked.

Only the bench scenarios show the remaining behaviour. These are the in-order data across slice boundaries, the exact slice each token reaches after a given number of transfers, the wrap from the last slice back to the first, and the behaviour of the flags while the buffer fills and drains under mixed traffic.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  // Token-passing link between neighbouring slices: one strobe per token kind
  typedef struct packed {
    logic wr;
    logic rd;
  } xfer_strobe_t;
endpackage

// File: rtl/cascade_slice.sv
module cascade_slice
  import cascade_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int DEPTH   = 4,
  parameter bit CASCADE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              first_load_i,
  input  xfer_strobe_t      xi_i,
  output xfer_strobe_t      xo_o,
  input  logic              wr_req_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  input  logic              rt_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              half_o,
  output logic              wr_tok_o,
  output logic              rd_tok_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  cnt;
  logic              wtok, rtok;
  logic              wr_go, rd_go, rt_go;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign half_o  = !CASCADE && (cnt > CNT_W'(DEPTH / 2));

  // cascade: ownership gates access; standalone: own flags gate access
  assign wr_go = wr_req_i && (CASCADE ? wtok : !full_o);
  assign rd_go = rd_req_i && (CASCADE ? rtok : !empty_o);
  assign rt_go = !CASCADE && rt_i;

  assign xo_o.wr = CASCADE && wr_go && (wptr == LAST);
  assign xo_o.rd = CASCADE && rd_go && (rptr == LAST);

  assign wr_tok_o  = wtok;
  assign rd_tok_o  = rtok;
  assign rd_data_o = mem[rptr];

  always_ff @(posedge clk_i) begin
    if (wr_go) mem[wptr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      wtok <= CASCADE ? first_load_i : 1'b1;
      rtok <= CASCADE ? first_load_i : 1'b1;
    end else begin
      if (wr_go) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rt_go) begin
        // standalone rewind, valid while fewer than DEPTH writes since reset
        rptr <= '0;
        cnt  <= CNT_W'(wptr) + CNT_W'(wr_go);
      end else begin
        if (rd_go) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
        cnt <= cnt + CNT_W'(wr_go) - CNT_W'(rd_go);
      end
      if (CASCADE) begin
        wtok <= (wtok && !xo_o.wr) || xi_i.wr;
        rtok <= (rtok && !xo_o.rd) || xi_i.rd;
      end
    end
  end

  assert_wr_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xo_o.wr && !xi_i.wr) |=> !wr_tok_o);
  assert_rd_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xo_o.rd && !xi_i.rd) |=> !rd_tok_o);
  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go |-> !full_o);
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go |-> !empty_o);

  if (CASCADE) begin : g_rt_chk
    assert_rt_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rt_i && !rd_go) |=> $stable(rptr));
  end
endmodule

// File: rtl/cascade_flag_merge.sv
module cascade_flag_merge #(
  parameter int NUM    = 3,
  parameter int DATA_W = 9
) (
  input  logic [NUM-1:0]             slice_empty_i,
  input  logic [NUM-1:0]             slice_full_i,
  input  logic [NUM-1:0]             slice_half_i,
  input  logic [NUM-1:0]             rd_tok_i,
  input  logic [NUM-1:0][DATA_W-1:0] slice_data_i,
  output logic                       empty_o,
  output logic                       full_o,
  output logic                       half_o,
  output logic [DATA_W-1:0]          rd_data_o
);
  assign empty_o = &slice_empty_i;
  assign full_o  = &slice_full_i;
  assign half_o  = |slice_half_i;

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM; i++) begin
      if (rd_tok_i[i]) rd_data_o = rd_data_o | slice_data_i[i];
    end
  end
endmodule

// File: rtl/cascade_fifo_top.sv
module cascade_fifo_top
  import cascade_pkg::*;
#(
  parameter int NUM_SLICES  = 3,
  parameter int SLICE_DEPTH = 4,
  parameter int DATA_W      = 9
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  rd_en_i,
  input  logic                  retransmit_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  empty_o,
  output logic                  full_o,
  output logic                  half_full_o,
  output logic [NUM_SLICES-1:0] wr_token_o,
  output logic [NUM_SLICES-1:0] rd_token_o
);
  xfer_strobe_t                     xo [NUM_SLICES];
  logic [NUM_SLICES-1:0]            s_empty, s_full, s_half;
  logic [NUM_SLICES-1:0][DATA_W-1:0] s_data;
  logic                             wr_acc, rd_acc;

  assign wr_acc = wr_en_i && !full_o;
  assign rd_acc = rd_en_i && !empty_o;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    localparam int PREV = (i == 0) ? NUM_SLICES - 1 : i - 1;
    cascade_slice #(
      .DATA_W (DATA_W),
      .DEPTH  (SLICE_DEPTH),
      .CASCADE(1'b1)
    ) u_slice (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .first_load_i(i == 0),
      .xi_i        (xo[PREV]),
      .xo_o        (xo[i]),
      .wr_req_i    (wr_acc),
      .wr_data_i   (wr_data_i),
      .rd_req_i    (rd_acc),
      .rt_i        (retransmit_i),
      .rd_data_o   (s_data[i]),
      .empty_o     (s_empty[i]),
      .full_o      (s_full[i]),
      .half_o      (s_half[i]),
      .wr_tok_o    (wr_token_o[i]),
      .rd_tok_o    (rd_token_o[i])
    );
  end

  cascade_flag_merge #(.NUM(NUM_SLICES), .DATA_W(DATA_W)) u_merge (
    .slice_empty_i(s_empty),
    .slice_full_i (s_full),
    .slice_half_i (s_half),
    .rd_tok_i     (rd_token_o),
    .slice_data_i (s_data),
    .empty_o      (empty_o),
    .full_o       (full_o),
    .half_o       (half_full_o),
    .rd_data_o    (rd_data_o)
  );

  assert_wr_token_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wr_token_o) == 1);
  assert_rd_token_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rd_token_o) == 1);
  assert_full_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_en_i) |=> (full_o && $stable(wr_token_o)));
  assert_empty_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !wr_en_i) |=> (empty_o && $stable(rd_token_o)));
  assert_no_half_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_full_o);
endmodule

// File: tb/cascade_fifo_top_tb.sv
module cascade_fifo_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int D = 4;
  localparam int W = 9;
  localparam int CAP = N * D;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0, rd_en_i = 1'b0, retransmit_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] rd_data_o;
  logic         empty_o, full_o, half_full_o;
  logic [N-1:0] wr_token_o, rd_token_o;

  int n_chk = 0, n_fail = 0;
  int gw = 0, gr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cascade_fifo_top #(.NUM_SLICES(N), .SLICE_DEPTH(D), .DATA_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .retransmit_i(retransmit_i), .rd_data_o(rd_data_o),
    .empty_o(empty_o), .full_o(full_o), .half_full_o(half_full_o),
    .wr_token_o(wr_token_o), .rd_token_o(rd_token_o));

  function automatic logic [W-1:0] pat(int k);
    return W'((k * 37 + 11) % 512);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare all outputs with the arithmetic model (called away from edges)
  task automatic cmp_all();
    int occ = gw - gr;
    int ew = 1 << ((gw / D) % N);
    int er = 1 << ((gr / D) % N);
    check(empty_o == (occ == 0), "R8/R11 empty", int'(empty_o), int'(occ == 0));
    check(full_o == (occ == CAP), "R8 full", int'(full_o), int'(occ == CAP));
    check(int'(wr_token_o) == ew, "R2/R4/R6 wr token", int'(wr_token_o), ew);
    check(int'(rd_token_o) == er, "R3/R5/R6 rd token", int'(rd_token_o), er);
    check(half_full_o == 1'b0, "R10 half_full", int'(half_full_o), 0);
    if (occ > 0)
      check(rd_data_o == pat(gr), "R7/R11 data", int'(rd_data_o), int'(pat(gr)));
  endtask

  task automatic cyc(bit w, bit r, bit rt);
    int occ;
    @(negedge clk);
    cmp_all();
    occ = gw - gr;
    wr_en_i      = w;
    rd_en_i      = r;
    retransmit_i = rt;
    wr_data_i    = (w && occ < CAP) ? pat(gw) : ~pat(gw);
    if (w && occ < CAP) gw++;   // R9: blocked when full
    if (r && occ > 0) gr++;     // R9: blocked when empty
    @(posedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    // R1: reset state
    check(wr_token_o == 1 && rd_token_o == 1, "R1 tokens in reset",
          int'({wr_token_o, rd_token_o}), 9);
    check(empty_o && !full_o, "R1 flags in reset", int'({empty_o, full_o}), 2);
    rst_ni = 1'b1;
    repeat (3) cyc(0, 0, 0);
    // fill across all slice boundaries, token wraps to slice 0 (R4, R6)
    for (int k = 0; k < CAP; k++) cyc(1, 0, 0);
    // writes while full ignored (R9), retransmit ignored (R10)
    for (int k = 0; k < 3; k++) cyc(1, 0, k == 1);
    // drain in order across boundaries (R5, R7)
    for (int k = 0; k < CAP; k++) cyc(0, 1, 0);
    // reads while empty ignored (R9)
    for (int k = 0; k < 3; k++) cyc(0, 1, 0);
    // mixed traffic with simultaneous read/write (R11) and retransmit pulses (R10)
    for (int k = 0; k < 600; k++) begin
      bit w, r;
      if ((k / 40) % 2 == 0) begin
        w = (k % 4 != 3);
        r = (k % 3 == 0);
      end else begin
        w = (k % 3 == 0);
        r = (k % 4 != 3);
      end
      cyc(w, r, k % 17 == 5);
    end
    for (int k = 0; k < CAP + 2; k++) cyc(0, 1, 0);
    @(negedge clk);
    cmp_all();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule